// File: doc/BRIEF.md
# Memory Address Range Protection Checker

This block screens every memory transaction against a small table of programmable protection rules and returns an accept or reject decision. Each rule covers an inclusive window of 1 MB address units, an inclusive range of master IDs, a set of ports and the security states it applies to. A rule also carries a valid flag and a result bit that says whether a hit is accepted or rejected.

Software never addresses the rule table directly. It fills three staging registers, picks a rule number in a control register and strobes either a copy into the rule or a fetch from the rule back into staging. A per-port default mask decides transactions that no valid rule claims.

The decision is registered. It appears one cycle after the transaction is presented, with a hit flag and the index of the deciding rule.

Top module: `mem_range_guard`

## Requirements
- R1: After reset every rule is invalid with all fields zero, the default mask and all staging registers read 0, and every transaction is accepted with `dec_hit` low.
- R2: Register indices are: 0 control (rule select in bits [4:0]), 1 address staging (low bound [11:0], high bound [23:12]), 2 ID staging (low ID [11:0], high ID [23:12]), 3 data staging (security [1:0], valid [2], port mask [12:3], result [13]), 4 default mask [9:0]. Unused read bits are 0, and strobe bits read back as 0.
- R3: A control write with bit 5 set copies the three staging registers into the selected rule. A control write with bit 6 set and bit 5 clear loads the selected rule into the staging registers. When both bits are set, only the copy takes place.
- R4: A control write whose select is 20 or more changes neither any rule nor the staging registers, but the select value still reads back.
- R5: A valid rule matches only if transaction address bits [31:20] lie between its low and high bounds, both inclusive.
- R6: A valid rule also requires the master ID to lie between its low and high IDs (inclusive), the port's bit to be set in its port mask, and security bit 1 to be set for a secure transaction or security bit 0 for a non-secure one.
- R7: On a hit, `dec_hit` is 1, `dec_rule` gives the rule index, and `dec_reject` equals the rule's result bit (0 accept, 1 reject).
- R8: When several rules match, the lowest-numbered rule decides.
- R9: On a miss, `dec_reject` equals the default-mask bit of the transaction's port. A port number of 10 or more is always rejected on a miss.
- R10: `dec_valid` is high exactly one cycle after `txn_valid`. When `dec_valid` is low, `dec_reject`, `dec_hit` and `dec_rule` are 0. A rule copied in a given cycle applies from the next transaction cycle onward.
- R11: A rule whose valid bit is 0 never matches, so copying all-zero staging into a rule clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational, from `reg_idx`) |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | 32 | Transaction byte address |
| txn_id | input | 12 | Master ID |
| txn_port | input | 4 | Port number |
| txn_secure | input | 1 | 1 for a secure transaction |
| dec_valid | output | 1 | Decision valid |
| dec_reject | output | 1 | 1 reject, 0 accept |
| dec_hit | output | 1 | A rule decided |
| dec_rule | output | 5 | Index of the deciding rule |

## Verification
A corrupted stored rule does not show at the ports until a transaction falls inside that rule's window. At that point `dec_reject` or `dec_rule` is wrong one cycle later. A corrupted rule can also be seen earlier, by a load strobe followed by a staging read. The bench therefore probes window edges (the first and last 1 MB unit, and one unit outside), ID edges, masked ports and both security states, and reads each rule back after writing it. A wrong priority order shows only when rules overlap, so overlapping rules with opposite results are set up on purpose. A broken default mask shows on the first miss on each affected port.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
   typedef enum logic [2:0] {
      IDX_CTRL  = 3'd0,
      IDX_ADDR  = 3'd1,
      IDX_ID    = 3'd2,
      IDX_DATA  = 3'd3,
      IDX_DEFLT = 3'd4
   } reg_idx_e;

   localparam int CTRL_COPY_BIT = 5;
   localparam int CTRL_LOAD_BIT = 6;
   localparam int REG_W         = 32;
endpackage

// File: rtl/mrg_rule_table.sv
module mrg_rule_table
   import mrg_pkg::*;
#(
   parameter int NUM_RULES = 20,
   parameter int SEL_W     = 5,
   parameter int BOUND_W   = 12,
   parameter int ID_W      = 12,
   parameter int PORTS     = 10,
   parameter int SEC_W     = 2,
   localparam int AW_W     = 2 * BOUND_W,
   localparam int IW_W     = 2 * ID_W,
   localparam int DW_W     = SEC_W + 2 + PORTS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [2:0]           reg_idx,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output logic [AW_W-1:0]      rule_addr [NUM_RULES],
   output logic [IW_W-1:0]      rule_id   [NUM_RULES],
   output logic [DW_W-1:0]      rule_data [NUM_RULES],
   output logic [PORTS-1:0]     def_mask,
   output logic [AW_W+IW_W+DW_W-1:0] stg_all
);
   localparam logic [SEL_W:0] NUM_L = (SEL_W+1)'(NUM_RULES);

   logic [SEL_W-1:0] sel_q;
   logic [AW_W-1:0]  stg_addr;
   logic [IW_W-1:0]  stg_id;
   logic [DW_W-1:0]  stg_data;
   logic [SEL_W-1:0] wsel;
   logic             wsel_ok;

   assign wsel    = reg_wdata[SEL_W-1:0];
   assign wsel_ok = {1'b0, wsel} < NUM_L;
   assign stg_all = {stg_addr, stg_id, stg_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         stg_addr <= '0;
         stg_id   <= '0;
         stg_data <= '0;
         def_mask <= '0;
         for (int r = 0; r < NUM_RULES; r++) begin
            rule_addr[r] <= '0;
            rule_id[r]   <= '0;
            rule_data[r] <= '0;
         end
      end else if (reg_we) begin
         case (reg_idx)
            IDX_CTRL: begin
               sel_q <= wsel;
               if (wsel_ok && reg_wdata[CTRL_COPY_BIT]) begin
                  rule_addr[wsel] <= stg_addr;
                  rule_id[wsel]   <= stg_id;
                  rule_data[wsel] <= stg_data;
               end else if (wsel_ok && reg_wdata[CTRL_LOAD_BIT]) begin
                  stg_addr <= rule_addr[wsel];
                  stg_id   <= rule_id[wsel];
                  stg_data <= rule_data[wsel];
               end
            end
            IDX_ADDR:  stg_addr <= reg_wdata[AW_W-1:0];
            IDX_ID:    stg_id   <= reg_wdata[IW_W-1:0];
            IDX_DATA:  stg_data <= reg_wdata[DW_W-1:0];
            IDX_DEFLT: def_mask <= reg_wdata[PORTS-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_idx)
         IDX_CTRL:  reg_rdata = REG_W'(sel_q);
         IDX_ADDR:  reg_rdata = REG_W'(stg_addr);
         IDX_ID:    reg_rdata = REG_W'(stg_id);
         IDX_DATA:  reg_rdata = REG_W'(stg_data);
         IDX_DEFLT: reg_rdata = REG_W'(def_mask);
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mrg_match.sv
module mrg_match #(
   parameter int NUM_RULES = 20,
   parameter int SEL_W     = 5,
   parameter int BOUND_W   = 12,
   parameter int ID_W      = 12,
   parameter int PORTS     = 10,
   parameter int PORT_W    = 4,
   parameter int SEC_W     = 2,
   parameter int ADDR_W    = 32,
   localparam int AW_W     = 2 * BOUND_W,
   localparam int IW_W     = 2 * ID_W,
   localparam int DW_W     = SEC_W + 2 + PORTS,
   localparam int VAL_POS  = SEC_W,
   localparam int PM_POS   = SEC_W + 1,
   localparam int RES_POS  = SEC_W + 1 + PORTS
) (
   input  logic [AW_W-1:0]   rule_addr [NUM_RULES],
   input  logic [IW_W-1:0]   rule_id   [NUM_RULES],
   input  logic [DW_W-1:0]   rule_data [NUM_RULES],
   input  logic [PORTS-1:0]  def_mask,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic [ID_W-1:0]   txn_id,
   input  logic [PORT_W-1:0] txn_port,
   input  logic              txn_secure,
   output logic              hit,
   output logic [SEL_W-1:0]  hit_idx,
   output logic              reject
);
   localparam logic [PORT_W:0] PORTS_L = (PORT_W+1)'(PORTS);

   logic [BOUND_W-1:0]   unit;
   logic                 port_ok;
   logic [NUM_RULES-1:0] match;

   assign unit    = txn_addr[ADDR_W-1 -: BOUND_W];
   assign port_ok = {1'b0, txn_port} < PORTS_L;

   for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
      logic [BOUND_W-1:0] lo_b, hi_b;
      logic [ID_W-1:0]    lo_i, hi_i;
      logic [PORTS-1:0]   pmask;
      logic [SEC_W-1:0]   sec;
      assign lo_b  = rule_addr[r][BOUND_W-1:0];
      assign hi_b  = rule_addr[r][AW_W-1:BOUND_W];
      assign lo_i  = rule_id[r][ID_W-1:0];
      assign hi_i  = rule_id[r][IW_W-1:ID_W];
      assign pmask = rule_data[r][PM_POS +: PORTS];
      assign sec   = rule_data[r][SEC_W-1:0];
      assign match[r] = rule_data[r][VAL_POS]
                        && (unit >= lo_b) && (unit <= hi_b)
                        && (txn_id >= lo_i) && (txn_id <= hi_i)
                        && port_ok && pmask[txn_port]
                        && sec[txn_secure];
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      reject  = port_ok ? def_mask[txn_port] : 1'b1;
      for (int r = NUM_RULES - 1; r >= 0; r--) begin
         if (match[r]) begin
            hit     = 1'b1;
            hit_idx = SEL_W'(r);
            reject  = rule_data[r][RES_POS];
         end
      end
   end
endmodule

// File: rtl/mem_range_guard.sv
module mem_range_guard #(
   parameter int NUM_RULES = 20,
   parameter int SEL_W     = 5,
   parameter int BOUND_W   = 12,
   parameter int ID_W      = 12,
   parameter int PORTS     = 10,
   parameter int PORT_W    = 4,
   parameter int SEC_W     = 2,
   parameter int ADDR_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_idx,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              txn_valid,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic [ID_W-1:0]   txn_id,
   input  logic [PORT_W-1:0] txn_port,
   input  logic              txn_secure,
   output logic              dec_valid,
   output logic              dec_reject,
   output logic              dec_hit,
   output logic [SEL_W-1:0]  dec_rule
);
   localparam int AW_W = 2 * BOUND_W;
   localparam int IW_W = 2 * ID_W;
   localparam int DW_W = SEC_W + 2 + PORTS;

   if (NUM_RULES > (1 << SEL_W)) begin : g_bad_sel
      $error("rule select too narrow for NUM_RULES");
   end
   if (SEL_W > mrg_pkg::CTRL_COPY_BIT) begin : g_bad_ctrl
      $error("rule select overlaps strobe bits");
   end
   if (AW_W > 32 || IW_W > 32 || DW_W > 32) begin : g_bad_stage
      $error("staging field does not fit a register");
   end
   if (SEC_W != 2) begin : g_bad_sec
      $error("security field must have two bits");
   end
   if ((1 << PORT_W) < PORTS || BOUND_W > ADDR_W) begin : g_bad_port
      $error("port or bound width inconsistent");
   end

   logic [AW_W-1:0]  rule_addr [NUM_RULES];
   logic [IW_W-1:0]  rule_id   [NUM_RULES];
   logic [DW_W-1:0]  rule_data [NUM_RULES];
   logic [PORTS-1:0] def_mask;
   logic [AW_W+IW_W+DW_W-1:0] stg_all;
   logic             m_hit, m_rej;
   logic [SEL_W-1:0] m_idx;

   mrg_rule_table #(
      .NUM_RULES(NUM_RULES), .SEL_W(SEL_W), .BOUND_W(BOUND_W),
      .ID_W(ID_W), .PORTS(PORTS), .SEC_W(SEC_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rule_addr(rule_addr), .rule_id(rule_id), .rule_data(rule_data),
      .def_mask(def_mask), .stg_all(stg_all)
   );

   mrg_match #(
      .NUM_RULES(NUM_RULES), .SEL_W(SEL_W), .BOUND_W(BOUND_W),
      .ID_W(ID_W), .PORTS(PORTS), .PORT_W(PORT_W), .SEC_W(SEC_W),
      .ADDR_W(ADDR_W)
   ) u_match (
      .rule_addr(rule_addr), .rule_id(rule_id), .rule_data(rule_data),
      .def_mask(def_mask), .txn_addr(txn_addr), .txn_id(txn_id),
      .txn_port(txn_port), .txn_secure(txn_secure),
      .hit(m_hit), .hit_idx(m_idx), .reject(m_rej)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_reject <= 1'b0;
         dec_hit    <= 1'b0;
         dec_rule   <= '0;
      end else begin
         dec_valid  <= txn_valid;
         dec_reject <= txn_valid & m_rej;
         dec_hit    <= txn_valid & m_hit;
         dec_rule   <= txn_valid ? m_idx : '0;
      end
   end
endmodule

// File: rtl/mrg_checker.sv
module mrg_checker #(
   parameter int NUM_RULES = 20,
   parameter int SEL_W     = 5,
   parameter int PORTS     = 10,
   parameter int PORT_W    = 4,
   parameter int STG_W     = 62
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [2:0]        reg_idx,
   input logic [31:0]       reg_wdata,
   input logic              txn_valid,
   input logic [PORT_W-1:0] txn_port,
   input logic              dec_valid,
   input logic              dec_reject,
   input logic              dec_hit,
   input logic [SEL_W-1:0]  dec_rule,
   input logic [PORTS-1:0]  def_mask,
   input logic [STG_W-1:0]  stg_all
);
   logic oor_sel, port_in;
   assign oor_sel = int'(reg_wdata[SEL_W-1:0]) >= NUM_RULES;
   assign port_in = int'(txn_port) < PORTS;

   AST_DEC_FOLLOWS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |=> dec_valid); // R10
   AST_DEC_NEEDS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> !dec_valid); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!dec_reject && !dec_hit && dec_rule == '0)); // R10
   AST_HIT_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_hit) |-> int'(dec_rule) < NUM_RULES); // R7
   AST_MISS_USES_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && port_in) |=> (dec_hit || dec_reject == $past(def_mask[txn_port]))); // R9
   AST_MISS_BAD_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !port_in) |=> (dec_hit || dec_reject)); // R9
   AST_OOR_SELECT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_idx == 3'd0 && oor_sel) |=> $stable(stg_all)); // R4
endmodule

bind mem_range_guard mrg_checker #(
   .NUM_RULES(NUM_RULES), .SEL_W(SEL_W), .PORTS(PORTS), .PORT_W(PORT_W),
   .STG_W(2*BOUND_W + 2*ID_W + SEC_W + 2 + PORTS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
   .reg_wdata(reg_wdata), .txn_valid(txn_valid), .txn_port(txn_port),
   .dec_valid(dec_valid), .dec_reject(dec_reject), .dec_hit(dec_hit),
   .dec_rule(dec_rule), .def_mask(def_mask), .stg_all(stg_all)
);

// File: tb/tb_mem_range_guard.sv
module tb_mem_range_guard;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_we = 0;
   logic [2:0]  reg_idx = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        txn_valid = 0;
   logic [31:0] txn_addr = 0;
   logic [11:0] txn_id = 0;
   logic [3:0]  txn_port = 0;
   logic        txn_secure = 0;
   logic        dec_valid, dec_reject, dec_hit;
   logic [4:0]  dec_rule;

   mem_range_guard dut (.*);

   always #5 clk = ~clk;

   int checks = 0, errors = 0;
   string tag = "R1";
   bit done = 0;

   // reference model state
   int m_addr [20], m_id [20], m_data [20];
   int s_addr, s_id, s_data, m_sel, m_def;
   int e_valid, e_rej, e_hit, e_rule;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_addr[r]) begin m_addr[r] = 0; m_id[r] = 0; m_data[r] = 0; end
         s_addr = 0; s_id = 0; s_data = 0; m_sel = 0; m_def = 0;
         e_valid = 0; e_rej = 0; e_hit = 0; e_rule = 0;
      end else begin
         int unit, wsel;
         e_valid = txn_valid; e_rej = 0; e_hit = 0; e_rule = 0;
         if (txn_valid) begin
            unit = int'(txn_addr >> 20);
            for (int r = 0; r < 20; r++) begin
               bit ok;
               ok = ((m_data[r] >> 2) & 1) == 1
                    && unit >= (m_addr[r] & 'hFFF) && unit <= ((m_addr[r] >> 12) & 'hFFF)
                    && int'(txn_id) >= (m_id[r] & 'hFFF) && int'(txn_id) <= ((m_id[r] >> 12) & 'hFFF)
                    && txn_port < 10 && ((m_data[r] >> (3 + txn_port)) & 1) == 1
                    && ((m_data[r] >> (txn_secure ? 1 : 0)) & 1) == 1;
               if (ok && !e_hit) begin
                  e_hit = 1; e_rule = r; e_rej = (m_data[r] >> 13) & 1;
               end
            end
            if (!e_hit) e_rej = (txn_port < 10) ? ((m_def >> txn_port) & 1) : 1;
         end
         if (reg_we) begin
            case (reg_idx)
               0: begin
                  wsel = reg_wdata & 31;
                  m_sel = wsel;
                  if (wsel < 20 && reg_wdata[5]) begin
                     m_addr[wsel] = s_addr; m_id[wsel] = s_id; m_data[wsel] = s_data;
                  end else if (wsel < 20 && reg_wdata[6]) begin
                     s_addr = m_addr[wsel]; s_id = m_id[wsel]; s_data = m_data[wsel];
                  end
               end
               1: s_addr = reg_wdata & 'hFFFFFF;
               2: s_id   = reg_wdata & 'hFFFFFF;
               3: s_data = reg_wdata & 'h3FFF;
               4: m_def  = reg_wdata & 'h3FF;
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (dec_valid !== e_valid[0] || dec_reject !== e_rej[0] ||
             dec_hit !== e_hit[0] || dec_rule !== 5'(e_rule)) begin
            errors++;
            $display("FAIL %s: dec v/rej/hit/rule = %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     tag, dec_valid, dec_reject, dec_hit, dec_rule, e_valid, e_rej, e_hit, e_rule);
         end
      end
   end

   task automatic wr(input int idx, input int data);
      @(negedge clk); reg_we = 1; reg_idx = 3'(idx); reg_wdata = 32'(data);
      @(negedge clk); reg_we = 0;
   endtask

   task automatic rd(input int idx, input int exp, input string t);
      @(negedge clk); reg_idx = 3'(idx); #1;
      checks++;
      if (reg_rdata !== 32'(exp)) begin
         errors++;
         $display("FAIL %s: reg %0d = %h expected %h", t, idx, reg_rdata, 32'(exp));
      end
   endtask

   task automatic tx(input int unit, input int low, input int id, input int port, input bit sec);
      @(negedge clk);
      txn_valid = 1; txn_addr = (32'(unit) << 20) | 32'(low);
      txn_id = 12'(id); txn_port = 4'(port); txn_secure = sec;
      @(negedge clk); txn_valid = 0;
   endtask

   task automatic rule(input int n, input int lo, input int hi, input int idl, input int idh,
                       input int pm, input int sec, input int res);
      wr(1, lo | (hi << 12));
      wr(2, idl | (idh << 12));
      wr(3, sec | (1 << 2) | (pm << 3) | (res << 13));
      wr(0, n | (1 << 5));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      tag = "R1";
      for (int i = 0; i < 5; i++) rd(i, 0, "R1 reset register");
      tx(0, 0, 0, 0, 0); tx('hFFF, 'hFFFFF, 'hFFF, 9, 1); tx(5, 3, 7, 4, 0);

      tag = "R3";
      rule(3, 'h010, 'h01F, 5, 9, 'b101, 2'b10, 1);
      wr(1, 'h123456); wr(2, 'h654321); wr(3, 'h3FFF);
      rd(1, 'h123456, "R2 addr staging mask");
      rd(2, 'h654321, "R2 id staging mask");
      rd(3, 'h3FFF, "R2 data staging mask");
      wr(0, 3 | (1 << 6));
      rd(0, 3, "R2 ctrl readback strobes zero");
      rd(1, 'h01F010, "R3 load addr");
      rd(2, 'h009005, "R3 load id");
      rd(3, 2 | 4 | ('b101 << 3) | (1 << 13), "R3 load data");

      tag = "R5";
      tx('h010, 0, 5, 0, 1); tx('h01F, 'hFFFFF, 5, 0, 1);
      tx('h020, 0, 5, 0, 1); tx('h00F, 'hFFFFF, 5, 0, 1);
      tag = "R6";
      tx('h015, 0, 4, 0, 1); tx('h015, 0, 9, 2, 1); tx('h015, 0, 10, 2, 1);
      tx('h015, 0, 7, 1, 1); tx('h015, 0, 7, 2, 0);
      tag = "R7";
      tx('h018, 7, 6, 2, 1);

      tag = "R8";
      rule(7, 0, 'hFFF, 0, 'hFFF, 'h3FF, 3, 0);
      tx('h012, 0, 6, 0, 1); tx('h200, 0, 6, 0, 0);
      rule(1, 'h011, 'h011, 6, 6, 1, 2'b10, 0);
      tx('h011, 0, 6, 0, 1); tx('h012, 0, 6, 0, 1);

      tag = "R11";
      wr(1, 0); wr(2, 0); wr(3, 0);
      wr(0, 7 | (1 << 5)); wr(0, 1 | (1 << 5));
      tx('h200, 0, 6, 0, 0); tx('h011, 0, 6, 0, 1);

      tag = "R9";
      wr(4, 'h3FF); rd(4, 'h3FF, "R2 default readback");
      tx('h300, 0, 0, 0, 0); tx('h300, 0, 0, 12, 0);
      wr(4, 'h200); tx('h300, 0, 0, 9, 1); tx('h300, 0, 0, 8, 1); tx('h300, 0, 0, 15, 0);

      tag = "R4";
      wr(1, 'hABCDEF); wr(3, 'h3FFF);
      wr(0, 25 | (1 << 5)); wr(0, 21 | (1 << 6));
      rd(0, 21, "R4 select readback");
      rd(1, 'hABCDEF, "R4 staging unchanged");
      rd(3, 'h3FFF, "R4 staging unchanged");
      tx('h3FF, 0, 0, 9, 1);

      tag = "R3";
      wr(1, 'h0FF0F0); wr(2, 'hFFF000); wr(3, 1 | 4 | ('h3FF << 3));
      wr(0, 19 | (1 << 5) | (1 << 6));
      rd(1, 'h0FF0F0, "R3 both strobes keep staging");
      tx('h0F5, 0, 3, 4, 0); tx('h0F5, 0, 3, 4, 1);

      tag = "R10";
      @(negedge clk); txn_valid = 1; txn_addr = 'h0F500000; txn_port = 1; txn_secure = 0;
      @(negedge clk); txn_addr = 'h40000000;
      @(negedge clk); txn_valid = 0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run incomplete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule